// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Timing Generator

This block makes the six gate-drive signals of a phase-shifted full-bridge converter from one system clock. A reference leg runs free as a complementary high/low pair at half duty, with a programmable dead time at each of its two transitions. A second complementary pair has the same shape. It starts a programmable number of clocks after the reference leg, and this phase offset is the value that sets the power transfer. Two synchronous-rectifier gates are also produced. Each is timed from one of the legs and conducts for the period minus the phase offset.

An external compensator writes the period, the dead time and the phase offset as clock counts. The block clamps them into a safe range and applies them only at a reference-leg period boundary. It also gives a one-clock start-of-period strobe for interrupts and a one-clock strobe in the middle of the active power-transfer interval for triggering the ADC. When the global enable is removed, every output goes low at the next clock edge.

Top module: `psfb_pwm`

## Requirements
- R1: The period P is `period_i` raised to at least 4, with half H = floor(P/2). Counting the clocks of a period as k = 0..P-1 from the start-of-period strobe, `fix_hi_o` is high for k in [dt, H) and `fix_lo_o` for k in [H+dt, P). The next strobe follows exactly P clocks later.
- R2: The shifted pair has the same shape on the count k' = (k - ph) mod P, so `sft_hi_o` first goes high at k = ph + dt.
- R3: The phase offset ph is `phase_i` limited to the range 0..H, and the dead time dt is `dead_i` limited to at most H-1.
- R4: `sr2_o` is high while k >= ph and `sr1_o` is high while k' >= ph, so each is high for P - ph clocks per period.
- R5: `sr1_en_i` low keeps `sr1_o` low and `sr2_en_i` low keeps `sr2_o` low, with no effect on the other outputs.
- R6: Period, dead time and phase are captured only at a period boundary (or while disabled). A change during a period first shows in the next period.
- R7: With `en_i` sampled low, all eight outputs are low after that clock edge. Once `en_i` is sampled high again, the next output cycle is the first clock of a new period and carries a start strobe.
- R8: `soc_o` is high for exactly one clock per period, on its first clock (k = 0).
- R9: `mid_o` is high for one clock per period at k = ph + floor((H - ph)/2).
- R10: The high and low gates of one leg are never high at the same time.
- R11: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable for switching |
| period_i | input | CNT_W | Period in clocks |
| dead_i | input | CNT_W | Dead time in clocks |
| phase_i | input | CNT_W | Phase offset of the shifted leg in clocks |
| sr1_en_i | input | 1 | Enable of rectifier 1 (shifted-leg timed) |
| sr2_en_i | input | 1 | Enable of rectifier 2 (reference-leg timed) |
| fix_hi_o | output | 1 | Reference leg high-side gate |
| fix_lo_o | output | 1 | Reference leg low-side gate |
| sft_hi_o | output | 1 | Shifted leg high-side gate |
| sft_lo_o | output | 1 | Shifted leg low-side gate |
| sr1_o | output | 1 | Rectifier 1 gate |
| sr2_o | output | 1 | Rectifier 2 gate |
| soc_o | output | 1 | Start-of-period strobe |
| mid_o | output | 1 | Mid-interval ADC trigger strobe |

## Verification
The assertions check these properties on every cycle: the two gates of a leg never overlap, a cleared enable blanks every output on the next clock, and a cleared rectifier enable keeps its gate low. They also check that the captured settings stay within their clamp limits and change only at a period boundary, and that the start strobe lasts one clock. The exact edge positions can only be shown by the bench scenarios, which measure over whole periods. These include the on-times of each gate, the phase of the shifted leg's first edge, the rectifier widths, the place of the mid strobe and the period length under clamping. The same holds for the one-period delay of a phase change made mid-period, and for the restart after re-enabling.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  // smallest period that still leaves a half of at least two clocks
  localparam int MIN_PERIOD = 4;

  typedef enum logic {
    LEG_FIXED = 1'b0,
    LEG_SHIFT = 1'b1
  } leg_e;
endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] phase_i,
  output logic [CNT_W-1:0] cnt_f,
  output logic [CNT_W-1:0] cnt_s,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] half_q,
  output logic [CNT_W-1:0] ph_q,
  output logic [CNT_W-1:0] dt_q,
  output logic [CNT_W-1:0] mid_q
);
  localparam logic [CNT_W-1:0] P_MIN = CNT_W'(psfb_pkg::MIN_PERIOD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] p_c, h_c, ph_c, dt_c, mid_c;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap, load;
  logic [CNT_W:0]   sft_sum;

  // clamp the incoming settings
  always_comb begin
    p_c   = (period_i < P_MIN) ? P_MIN : period_i;
    h_c   = p_c >> 1;
    ph_c  = (phase_i > h_c) ? h_c : phase_i;
    dt_c  = (dead_i >= h_c) ? (h_c - ONE) : dead_i;
    mid_c = ph_c + ((h_c - ph_c) >> 1);
  end

  // counter next state
  always_comb begin
    wrap = (cnt_f == (per_q - ONE));
    load = !en_i || wrap;
    if (!en_i || wrap) cnt_nxt = '0;
    else               cnt_nxt = cnt_f + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_f <= '0;
    else        cnt_f <= cnt_nxt;
  end

  // settings register, enabled at the boundary only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= P_MIN;
      half_q <= P_MIN >> 1;
      ph_q   <= '0;
      dt_q   <= '0;
      mid_q  <= P_MIN >> 2;
    end else if (load) begin
      per_q  <= p_c;
      half_q <= h_c;
      ph_q   <= ph_c;
      dt_q   <= dt_c;
      mid_q  <= mid_c;
    end
  end

  // shifted-leg count: reference count delayed by ph, modulo the period
  always_comb begin
    sft_sum = {1'b0, cnt_f} + {1'b0, per_q} - {1'b0, ph_q};
    if (cnt_f >= ph_q) cnt_s = cnt_f - ph_q;
    else               cnt_s = sft_sum[CNT_W-1:0];
  end
endmodule

// File: rtl/psfb_leg.sv
module psfb_leg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] dt_i,
  output logic             hi_o,
  output logic             lo_o
);
  logic hi_nxt, lo_nxt;
  logic [CNT_W-1:0] lo_start;

  always_comb begin
    lo_start = half_i + dt_i;
    hi_nxt   = en_i && (cnt_i >= dt_i) && (cnt_i < half_i);
    lo_nxt   = en_i && (cnt_i >= lo_start) && (cnt_i < per_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
    end else begin
      hi_o <= hi_nxt;
      lo_o <= lo_nxt;
    end
  end
endmodule

// File: rtl/psfb_sr.sv
module psfb_sr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             sr_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ph_i,
  output logic             sr_o
);
  logic sr_nxt;

  // generator pulse covers [0, ph); the swapped side drives the gate
  always_comb sr_nxt = en_i && sr_en_i && !(cnt_i < ph_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_o <= 1'b0;
    else        sr_o <= sr_nxt;
  end
endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             sr1_en_i,
  input  logic             sr2_en_i,
  output logic             fix_hi_o,
  output logic             fix_lo_o,
  output logic             sft_hi_o,
  output logic             sft_lo_o,
  output logic             sr1_o,
  output logic             sr2_o,
  output logic             soc_o,
  output logic             mid_o
);
  localparam int NLEG = 2;

  logic [CNT_W-1:0] cnt_f, cnt_s, per_q, half_q, ph_q, dt_q, mid_q;
  logic [CNT_W-1:0] leg_cnt [NLEG];
  logic             leg_hi  [NLEG];
  logic             leg_lo  [NLEG];
  logic             leg_sren[NLEG];
  logic             leg_sr  [NLEG];
  logic             soc_nxt, mid_nxt;

  psfb_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .period_i(period_i), .dead_i(dead_i), .phase_i(phase_i),
    .cnt_f(cnt_f), .cnt_s(cnt_s), .per_q(per_q), .half_q(half_q),
    .ph_q(ph_q), .dt_q(dt_q), .mid_q(mid_q)
  );

  // index LEG_FIXED: reference leg, rectifier 2; LEG_SHIFT: shifted leg, rectifier 1
  generate
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
      if (g == int'(psfb_pkg::LEG_FIXED)) begin : g_ref
        assign leg_cnt[g]  = cnt_f;
        assign leg_sren[g] = sr2_en_i;
      end else begin : g_sft
        assign leg_cnt[g]  = cnt_s;
        assign leg_sren[g] = sr1_en_i;
      end

      psfb_leg #(.CNT_W(CNT_W)) u_leg (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .cnt_i(leg_cnt[g]),
        .per_i(per_q), .half_i(half_q), .dt_i(dt_q),
        .hi_o(leg_hi[g]), .lo_o(leg_lo[g])
      );

      psfb_sr #(.CNT_W(CNT_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .sr_en_i(leg_sren[g]),
        .cnt_i(leg_cnt[g]), .ph_i(ph_q), .sr_o(leg_sr[g])
      );
    end
  endgenerate

  always_comb begin
    soc_nxt = en_i && (cnt_f == '0);
    mid_nxt = en_i && (cnt_f == mid_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soc_o <= 1'b0;
      mid_o <= 1'b0;
    end else begin
      soc_o <= soc_nxt;
      mid_o <= mid_nxt;
    end
  end

  assign fix_hi_o = leg_hi[int'(psfb_pkg::LEG_FIXED)];
  assign fix_lo_o = leg_lo[int'(psfb_pkg::LEG_FIXED)];
  assign sft_hi_o = leg_hi[int'(psfb_pkg::LEG_SHIFT)];
  assign sft_lo_o = leg_lo[int'(psfb_pkg::LEG_SHIFT)];
  assign sr2_o    = leg_sr[int'(psfb_pkg::LEG_FIXED)];
  assign sr1_o    = leg_sr[int'(psfb_pkg::LEG_SHIFT)];
endmodule

// File: rtl/psfb_pwm_chk.sv
module psfb_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             sr1_en_i,
  input logic             sr2_en_i,
  input logic             fix_hi_o,
  input logic             fix_lo_o,
  input logic             sft_hi_o,
  input logic             sft_lo_o,
  input logic             sr1_o,
  input logic             sr2_o,
  input logic             soc_o,
  input logic             mid_o,
  input logic [CNT_W-1:0] cnt_f,
  input logic [CNT_W-1:0] per_q,
  input logic [CNT_W-1:0] half_q,
  input logic [CNT_W-1:0] ph_q,
  input logic [CNT_W-1:0] dt_q
);
  AST_FIX_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n) !(fix_hi_o && fix_lo_o)); // R10
  AST_SFT_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n) !(sft_hi_o && sft_lo_o)); // R10
  AST_DISABLE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !(fix_hi_o || fix_lo_o || sft_hi_o || sft_lo_o || sr1_o || sr2_o || soc_o || mid_o)); // R7
  AST_SR1_GATED: assert property (@(posedge clk) disable iff (!rst_n) !sr1_en_i |=> !sr1_o); // R5
  AST_SR2_GATED: assert property (@(posedge clk) disable iff (!rst_n) !sr2_en_i |=> !sr2_o); // R5
  AST_SOC_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) soc_o |=> !soc_o); // R8
  AST_PHASE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n) ph_q <= (per_q >> 1)); // R3
  AST_DEAD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n) dt_q < half_q); // R3
  AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && cnt_f != '0) |-> ($stable(per_q) && $stable(ph_q) && $stable(dt_q))); // R6
endmodule

bind psfb_pwm psfb_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .sr1_en_i(sr1_en_i), .sr2_en_i(sr2_en_i),
  .fix_hi_o(fix_hi_o), .fix_lo_o(fix_lo_o), .sft_hi_o(sft_hi_o), .sft_lo_o(sft_lo_o),
  .sr1_o(sr1_o), .sr2_o(sr2_o), .soc_o(soc_o), .mid_o(mid_o),
  .cnt_f(cnt_f), .per_q(per_q), .half_q(half_q), .ph_q(ph_q), .dt_q(dt_q)
);

// File: tb/psfb_pwm_tb.sv
module psfb_pwm_tb;
  localparam int CNT_W = 16;
  localparam int NVEC  = 6;
  // period, dead, phase, effective period, fix_hi clocks, fix_lo clocks,
  // first sft_hi index, rectifier clocks, mid index
  localparam int VEC [NVEC][9] = '{
    '{20,  2,  5, 20, 8, 8,  7, 15,  7},
    '{21,  3,  0, 21, 7, 8,  3, 21,  5},
    '{16,  0,  8, 16, 8, 8,  8,  8,  8},
    '{20,  2, 15, 20, 8, 8, 12, 10, 10},
    '{20, 15,  4, 20, 1, 1, 13, 16,  7},
    '{ 2,  0,  1,  4, 2, 2,  1,  3,  1}
  };

  logic clk, rst_n, en_i, sr1_en_i, sr2_en_i;
  logic [CNT_W-1:0] period_i, dead_i, phase_i;
  logic fix_hi_o, fix_lo_o, sft_hi_o, sft_lo_o, sr1_o, sr2_o, soc_o, mid_o;
  int n_run, n_fail;
  bit done;

  psfb_pwm #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .period_i(period_i), .dead_i(dead_i), .phase_i(phase_i),
    .sr1_en_i(sr1_en_i), .sr2_en_i(sr2_en_i),
    .fix_hi_o(fix_hi_o), .fix_lo_o(fix_lo_o), .sft_hi_o(sft_hi_o), .sft_lo_o(sft_lo_o),
    .sr1_o(sr1_o), .sr2_o(sr2_o), .soc_o(soc_o), .mid_o(mid_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {fix_hi_o, fix_lo_o, sft_hi_o, sft_lo_o, sr1_o, sr2_o, soc_o, mid_o};
  endfunction

  task automatic wait_soc();
    @(negedge clk);
    while (!soc_o) @(negedge clk);
  endtask

  // starts at the negedge of index 0, ends at the negedge of the next index 0
  task automatic measure(input int effp, output int fhi, output int flo, output int shi,
                         output int slo, output int s1, output int s2, output int prise,
                         output int midi, output int socc);
    fhi = 0; flo = 0; shi = 0; slo = 0; s1 = 0; s2 = 0; socc = 0;
    prise = -1; midi = -1;
    for (int i = 0; i < effp; i++) begin
      if (fix_hi_o) fhi++;
      if (fix_lo_o) flo++;
      if (sft_hi_o) shi++;
      if (sft_lo_o) slo++;
      if (sr1_o) s1++;
      if (sr2_o) s2++;
      if (soc_o) socc++;
      if (sft_hi_o && prise < 0) prise = i;
      if (mid_o && midi < 0) midi = i;
      @(negedge clk);
    end
  endtask

  initial begin
    int fhi, flo, shi, slo, s1, s2, prise, midi, socc;
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; en_i = 1'b0; sr1_en_i = 1'b1; sr2_en_i = 1'b1;
    period_i = 16'd20; dead_i = 16'd2; phase_i = 16'd5;
    repeat (3) @(negedge clk);
    chk(outs() == 0, "R11 outputs in reset", outs(), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(outs() == 0, "R11 outputs after reset, disabled", outs(), 0);
    en_i = 1'b1;

    // table of settings walked by one loop
    for (int v = 0; v < NVEC; v++) begin
      period_i = CNT_W'(VEC[v][0]); dead_i = CNT_W'(VEC[v][1]); phase_i = CNT_W'(VEC[v][2]);
      wait_soc(); wait_soc();
      measure(VEC[v][3], fhi, flo, shi, slo, s1, s2, prise, midi, socc);
      chk(fhi == VEC[v][4], "R1 R3 fix_hi clocks", fhi, VEC[v][4]);
      chk(flo == VEC[v][5], "R1 R3 fix_lo clocks", flo, VEC[v][5]);
      chk(soc_o == 1'b1, "R1 period length", int'(soc_o), 1);
      chk(shi == VEC[v][4] && slo == VEC[v][5], "R2 shifted leg shape", shi*100 + slo, VEC[v][4]*100 + VEC[v][5]);
      chk(prise == VEC[v][6], "R2 R3 shifted rise index", prise, VEC[v][6]);
      chk(s1 == VEC[v][7], "R4 sr1 clocks", s1, VEC[v][7]);
      chk(s2 == VEC[v][7], "R4 sr2 clocks", s2, VEC[v][7]);
      chk(midi == VEC[v][8], "R9 mid index", midi, VEC[v][8]);
      chk(socc == 1, "R8 one strobe per period", socc, 1);
    end

    // R6: phase change mid-period waits for the boundary
    period_i = 16'd20; dead_i = 16'd2; phase_i = 16'd5;
    wait_soc(); wait_soc();
    phase_i = 16'd0;
    measure(20, fhi, flo, shi, slo, s1, s2, prise, midi, socc);
    chk(prise == 7, "R6 current period keeps old phase", prise, 7);
    measure(20, fhi, flo, shi, slo, s1, s2, prise, midi, socc);
    chk(prise == 2, "R6 next period uses new phase", prise, 2);

    // R5: per-rectifier enables
    phase_i = 16'd6; sr1_en_i = 1'b0;
    wait_soc(); wait_soc();
    measure(20, fhi, flo, shi, slo, s1, s2, prise, midi, socc);
    chk(s1 == 0, "R5 sr1 held off", s1, 0);
    chk(s2 == 14 && fhi == 8, "R5 others unaffected", s2, 14);
    sr1_en_i = 1'b1; sr2_en_i = 1'b0;
    wait_soc(); wait_soc();
    measure(20, fhi, flo, shi, slo, s1, s2, prise, midi, socc);
    chk(s2 == 0 && s1 == 14, "R5 sr2 held off, sr1 active", s2*100 + s1, 14);
    sr2_en_i = 1'b1;

    // R7: disable mid-period blanks outputs, re-enable restarts the period
    repeat (3) @(negedge clk);
    chk(fix_hi_o == 1'b1, "R7 precondition: gate active", int'(fix_hi_o), 1);
    en_i = 1'b0;
    @(negedge clk);
    chk(outs() == 0, "R7 all low one clock after disable", outs(), 0);
    repeat (4) @(negedge clk);
    chk(outs() == 0, "R7 stays low while disabled", outs(), 0);
    en_i = 1'b1;
    @(negedge clk);
    chk(soc_o == 1'b1, "R7 R8 restart with start strobe", int'(soc_o), 1);
    measure(20, fhi, flo, shi, slo, s1, s2, prise, midi, socc);
    chk(fhi == 8 && soc_o == 1'b1, "R7 first period after restart is whole", fhi, 8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule